// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of single-word accesses. A request carries a base address, a contiguous register range given by its first and last index, a 4-bit mask that picks any of the four highest registers (r28 to r31), and three mode bits: pre-advance or post-advance, rising or falling direction, and base writeback. The block then emits one register index and one word address per handshake on its access port.

Registers are always issued in ascending index order at ascending word addresses, whatever the direction. A falling operation therefore starts at the low end of the block, which lies below the base. After the last access the block raises a one-cycle completion strobe. With that strobe it gives the updated base value when writeback was requested, and a flag that reports a base address that is not word aligned. Unaligned bases are still sequenced as given, with no realignment.

The pipeline stage that holds the register file and the memory port drives the request port and consumes the access stream. It holds the data path in step with each accepted access.

Top module: `lsm_addr_seq`

## Requirements
- R1: The transferred set is every register from the first to the last index, cut off so that it never reaches past r27, plus register r28+k for each set bit k of the mask. When first is greater than last, the range adds nothing and only the mask registers are transferred.
- R2: Registers come out in strictly ascending index order. Each access address is exactly 4 above the address of the access before it.
- R3: With the rising direction, the first address is the base in post-advance mode and base+4 in pre-advance mode.
- R4: With the falling direction and n registers, the first (lowest) address is base-4n+4 in post-advance mode and base-4n in pre-advance mode.
- R5: At completion, wb_en is 1 only if writeback was requested. wb_value is then base+4n for rising and base-4n for falling operations.
- R6: While acc_valid is 1 and acc_ready is 0, acc_reg and acc_addr hold their values. Exactly one register is consumed per cycle with both high.
- R7: A request that selects no register gives done in the first cycle after acceptance and issues no access.
- R8: done is a single-cycle pulse in the cycle after the final access handshake. req_ready is 1 only while the block is idle, and it is 1 again in the cycle after done.
- R9: misaligned is 1 together with done exactly when bits [1:0] of the base were not both zero. Addresses are not realigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_base | input | ADDR_W | Base address |
| req_first | input | IDX_W | First register of the range |
| req_last | input | IDX_W | Last register of the range |
| req_top_mask | input | TOPN | Bit k selects register NREG-TOPN+k |
| req_pre | input | 1 | 1: advance before access, 0: after |
| req_down | input | 1 | 1: falling direction, 0: rising |
| req_wb | input | 1 | Request base writeback |
| acc_valid | output | 1 | Access present |
| acc_ready | input | 1 | Consumer takes the access |
| acc_reg | output | IDX_W | Register index of the access |
| acc_addr | output | ADDR_W | Word address of the access |
| done | output | 1 | One-cycle completion strobe |
| wb_en | output | 1 | Writeback value valid (with done) |
| wb_value | output | ADDR_W | New base value |
| misaligned | output | 1 | Base not word aligned (with done) |

## Verification
Two events can collide in one cycle: the final access handshake, and the return to idle with the writeback and alignment results. Ranges that touch the mask registers and ranges that are empty are also sequenced with a stalling consumer. The scoreboard shows whether the last access is lost, repeated or merged with done. A request with no registers forces completion to follow acceptance at once. The bench judges that case by the exact cycle count to done and by the absence of any access.

// File: rtl/lsm_pkg.sv
// Shared types and constants for the load/store-multiple sequencer.
// Assumes 4-byte words.
package lsm_pkg;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } lsm_state_t;
endpackage

// File: rtl/lsm_regset.sv
// Builds the selection vector of registers to transfer from a range and a
// top-register mask, and counts its members. Range members are clipped below
// the top group; an inverted range (first > last) selects nothing.
module lsm_regset #(
    parameter int NREG  = 32,
    parameter int TOPN  = 4,
    parameter int IDX_W = $clog2(NREG),
    parameter int CNT_W = $clog2(NREG + 1)
) (
    input  logic [IDX_W-1:0] first,
    input  logic [IDX_W-1:0] last,
    input  logic [TOPN-1:0]  top_mask,
    output logic [NREG-1:0]  sel,
    output logic [CNT_W-1:0] count
);
    localparam int LOW_TOP = NREG - TOPN;

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        if (g < LOW_TOP) begin : g_range
            assign sel[g] = (IDX_W'(g) >= first) && (IDX_W'(g) <= last);
        end else begin : g_top
            assign sel[g] = top_mask[g - LOW_TOP];
        end
    end

    // Population count of the selection.
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CNT_W'(sel[i]);
        end
    end
endmodule

// File: rtl/lsm_lowest.sv
// Priority encoder: index of the lowest set bit. Output is 0 for an empty
// vector; the caller guards with its own state.
module lsm_lowest #(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  vec,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lsm_addr_plan.sv
// Computes the lowest access address and the writeback value for an
// operation of count words. Assumes ascending placement in both directions.
module lsm_addr_plan
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              pre,
    input  logic              down,
    output logic [ADDR_W-1:0] low_addr,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    assign span = ADDR_W'(count) * STEP;

    // Select start point and final base from direction and advance timing.
    always_comb begin
        if (down) begin
            wb_addr  = base - span;
            low_addr = pre ? (base - span) : (base - span + STEP);
        end else begin
            wb_addr  = base + span;
            low_addr = pre ? (base + STEP) : base;
        end
    end
endmodule

// File: rtl/lsm_addr_seq.sv
// Load/store-multiple address sequencer. Accepts one request when idle,
// emits one (register, word address) pair per access handshake in ascending
// order, then pulses done with writeback and alignment results.
// Assumes the consumer holds the data path in step with each handshake.
module lsm_addr_seq
    import lsm_pkg::*;
#(
    parameter int NREG   = 32,
    parameter int TOPN   = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = $clog2(NREG),
    parameter int CNT_W  = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [IDX_W-1:0]  req_first,
    input  logic [IDX_W-1:0]  req_last,
    input  logic [TOPN-1:0]   req_top_mask,
    input  logic              req_pre,
    input  logic              req_down,
    input  logic              req_wb,
    output logic              acc_valid,
    input  logic              acc_ready,
    output logic [IDX_W-1:0]  acc_reg,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              done,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value,
    output logic              misaligned
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    lsm_state_t        st;
    logic [NREG-1:0]   rem;
    logic [NREG-1:0]   rem_next;
    logic [NREG-1:0]   sel;
    logic [CNT_W-1:0]  count;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] low_addr;
    logic [ADDR_W-1:0] wb_calc;
    logic [ADDR_W-1:0] wb_q;
    logic              wb_req_q;
    logic              misal_q;
    logic [IDX_W-1:0]  cur_idx;
    logic              accept;

    lsm_regset #(.NREG(NREG), .TOPN(TOPN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_set (
        .first    (req_first),
        .last     (req_last),
        .top_mask (req_top_mask),
        .sel      (sel),
        .count    (count)
    );

    lsm_addr_plan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_plan (
        .base     (req_base),
        .count    (count),
        .pre      (req_pre),
        .down     (req_down),
        .low_addr (low_addr),
        .wb_addr  (wb_calc)
    );

    lsm_lowest #(.NREG(NREG), .IDX_W(IDX_W)) u_pick (
        .vec (rem),
        .idx (cur_idx)
    );

    // Handshake decode and remaining set after the current register.
    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rem_next  = rem & ~(NREG'(1) << cur_idx);

    // Sequencer state, remaining set and running address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rem      <= '0;
            addr_q   <= '0;
            wb_q     <= '0;
            wb_req_q <= 1'b0;
            misal_q  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    rem      <= sel;
                    addr_q   <= low_addr;
                    wb_q     <= wb_calc;
                    wb_req_q <= req_wb;
                    misal_q  <= |req_base[1:0];
                    st       <= (count == '0) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (acc_ready) begin
                    rem    <= rem_next;
                    addr_q <= addr_q + STEP;
                    if (rem_next == '0) st <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    assign acc_valid  = (st == ST_RUN);
    assign acc_reg    = cur_idx;
    assign acc_addr   = addr_q;
    assign done       = (st == ST_FIN);
    assign wb_en      = done && wb_req_q;
    assign wb_value   = wb_q;
    assign misaligned = done && misal_q;
endmodule

// File: rtl/lsm_addr_seq_chk.sv
// Protocol checker for the sequencer, attached by bind. Observes ports only.
module lsm_addr_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic [IDX_W-1:0]  acc_reg,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              done,
    input logic              wb_en
);
    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_reg) && $stable(acc_addr)));

    // R2
    ascending_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_ready) |=>
            (!acc_valid || ((acc_addr == $past(acc_addr) + ADDR_W'(4)) && (acc_reg > $past(acc_reg)))));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R8
    idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && (done || req_ready)));

    // R5
    wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .acc_reg   (acc_reg),
    .acc_addr  (acc_addr),
    .done      (done),
    .wb_en     (wb_en)
);

// File: tb/lsm_addr_seq_test.sv
// Scoreboard bench: run_op pushes the expected accesses, the monitor pops
// and compares them at each handshake, run_op then checks completion.
module lsm_addr_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [4:0]  req_first = '0;
    logic [4:0]  req_last = '0;
    logic [3:0]  req_top_mask = '0;
    logic        req_pre = 1'b0;
    logic        req_down = 1'b0;
    logic        req_wb = 1'b0;
    logic        acc_valid;
    logic        acc_ready = 1'b1;
    logic [4:0]  acc_reg;
    logic [31:0] acc_addr;
    logic        done;
    logic        wb_en;
    logic [31:0] wb_value;
    logic        misaligned;

    int total = 0;
    int fails = 0;
    int seen = 0;
    bit stall_en = 1'b0;
    logic [4:0]  exp_reg[$];
    logic [31:0] exp_addr[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lsm_addr_seq uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
        .req_first(req_first), .req_last(req_last), .req_top_mask(req_top_mask),
        .req_pre(req_pre), .req_down(req_down), .req_wb(req_wb),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_reg(acc_reg),
        .acc_addr(acc_addr), .done(done), .wb_en(wb_en), .wb_value(wb_value),
        .misaligned(misaligned)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Consumer back-pressure pattern, changed just after each rising edge.
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            acc_ready = !stall_en || (cyc % 3 != 0);
        end
    end

    // Monitor: compare every handshake against the scoreboard (R1, R2, R6).
    always @(negedge clk) begin
        if (rst_n && acc_valid && acc_ready) begin
            seen++;
            if (exp_reg.size() == 0) begin
                chk(1'b0, "R1", "unexpected access reg", 32'(acc_reg), 32'hffffffff);
            end else begin
                logic [4:0]  er;
                logic [31:0] ea;
                er = exp_reg.pop_front();
                ea = exp_addr.pop_front();
                chk(acc_reg == er, "R2", "access register", 32'(acc_reg), 32'(er));
                chk(acc_addr == ea, "R2", "access address", acc_addr, ea);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 32'd0, 32'd1);
        finish_run();
    end

    task automatic run_op(input logic [31:0] base, input int first, input int last,
                          input logic [3:0] mask, input bit pre, input bit down,
                          input bit wb, input bit stall);
        logic [4:0]  regs[$];
        logic [31:0] low;
        logic [31:0] wbv;
        int n;
        int lat;
        for (int i = first; i <= last && i <= 27; i++) regs.push_back(5'(i));
        for (int k = 0; k < 4; k++) if (mask[k]) regs.push_back(5'(28 + k));
        n = regs.size();
        if (!down) begin
            wbv = base + 32'(4 * n);
            low = pre ? base + 32'd4 : base;
        end else begin
            wbv = base - 32'(4 * n);
            low = pre ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
        end
        foreach (regs[j]) begin
            exp_reg.push_back(regs[j]);
            exp_addr.push_back(low + 32'(4 * j));
        end
        seen = 0;
        stall_en = stall;
        @(posedge clk);
        #1;
        req_valid = 1'b1; req_base = base; req_first = 5'(first); req_last = 5'(last);
        req_top_mask = mask; req_pre = pre; req_down = down; req_wb = wb;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8", "ready before accept", 32'(req_ready), 32'd1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 400);
        if (n == 0) chk(lat == 1, "R7", "empty op latency", 32'(lat), 32'd1);
        chk(seen == n, "R1", "access count", 32'(seen), 32'(n));
        chk(wb_en == wb, "R5", "wb_en", 32'(wb_en), 32'(wb));
        if (wb) chk(wb_value == wbv, "R5", "wb_value", wb_value, wbv);
        chk(misaligned == (base[1:0] != 2'b00), "R9", "misaligned",
            32'(misaligned), 32'(base[1:0] != 2'b00));
        @(negedge clk);
        chk(!done && req_ready, "R8", "idle after done", {30'd0, done, req_ready}, 32'd1);
        exp_reg.delete();
        exp_addr.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !acc_valid && !done, "R8", "reset state",
            {29'd0, req_ready, acc_valid, done}, 32'h4);
        // R3: rising, post-advance, plain range
        run_op(32'h0000_2000, 2, 5, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b0);
        // R3: rising, pre-advance, range plus mask, stalls (R6)
        run_op(32'h0000_3000, 7, 9, 4'b1001, 1'b1, 1'b0, 1'b1, 1'b1);
        // R4: falling post-advance, r0..r5 with r30,r31: base lowered by 32
        run_op(32'h0000_1000, 0, 5, 4'b1100, 1'b0, 1'b1, 1'b1, 1'b0);
        // R4: falling pre-advance with stalls
        run_op(32'h0000_1800, 10, 12, 4'b0001, 1'b1, 1'b1, 1'b1, 1'b1);
        // R1: inverted range leaves only mask registers
        run_op(32'h0000_4000, 9, 3, 4'b0101, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: range reaching into the top group is clipped at r27
        run_op(32'h0000_5000, 25, 31, 4'b0010, 1'b0, 1'b0, 1'b1, 1'b1);
        // R7: nothing selected
        run_op(32'h0000_6000, 5, 3, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0);
        // R9: unaligned base, no realignment
        run_op(32'h0000_7002, 1, 2, 4'b0000, 1'b1, 1'b1, 1'b1, 1'b1);
        // R5: writeback not requested, single register
        run_op(32'h0000_8000, 31, 31, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0);
        // R2: full range and all top registers under stalls
        run_op(32'h0001_0000, 0, 27, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b1);
        finish_run();
    end
endmodule